// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter

This block chooses which event the processor services next. It takes a set of peripheral request flags, each with its own programmable priority level and a tie-breaking sub-priority, plus software trap requests and two hardware fault strobes: a word data access to an odd address and a branch to an odd address. Each cycle it picks one winner and registers an acknowledge. The acknowledge carries a vector index, the priority level the processor runs at from then on, and a one-cycle clear pulse back to the peripheral whose flag won.

Each peripheral has its own level, so no two sources are tied to a shared level. Priority levels 1 to `MAX_LVL` (default 14) are usable, and level 0 turns a source off. A peripheral wins only if its level is strictly above the current processor level. Hardware traps ignore the processor level because they must always be serviced. A software trap keeps the level the processor already has. The issuing cycle of an acknowledge is followed by one quiet cycle, in which the processor can update its level and the peripheral can drop its flag. Requests that arrive during the acknowledge stay pending and compete in the cycle after it.

Top module: `irq_arbiter`

## Requirements
- R1: During reset and in every cycle without an acknowledge, `take` is 0 and `vec`, `new_lvl` and `irq_clr` are all zero.
- R2: A peripheral request is acknowledged only if its level is non-zero, at most `MAX_LVL`, and strictly greater than `cpu_lvl`. Otherwise it is never taken.
- R3: Among eligible peripheral requests, the one with the highest level wins.
- R4: If eligible requests have equal levels, the larger sub-priority field wins (unsigned). If level and sub-priority are both equal, the lowest source index wins.
- R5: Peripheral requests present before clock edge t are acknowledged after edge t. The acknowledge has `take`=1, `vec` = `IRQ_VEC_BASE` + source index, `new_lvl` = the source's level, and `irq_clr` = one-hot at the winning index, all in the same cycle.
- R6: A software trap beats every peripheral request. It gives `vec` = its `swt_num` and `new_lvl` = `cpu_lvl` as seen in the cycle it is accepted, with `irq_clr` zero. A trap held pending keeps its number, and further `swt_req` pulses are ignored while it waits.
- R7: Hardware traps are taken whatever `cpu_lvl` is and beat software traps. An odd-branch fault gives `vec` = `HWT_BR_VEC` and an odd-data fault gives `vec` = `HWT_DATA_VEC`, both with `new_lvl` = `HWT_LVL` and `irq_clr` zero. If both are pending, the branch fault is taken first.
- R8: `take` is never high in two consecutive cycles. A trap strobe or request that loses, or that arrives during an acknowledge cycle, stays pending and is acknowledged in a later cycle without being lost.
- R9: `irq_clr` has at most one bit set, and only while `take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Peripheral request flags, held high until cleared |
| irq_lvl | input | NUM_SRC*LVL_W | Priority level per source, source i at bits i*LVL_W upward |
| irq_sub | input | NUM_SRC*SUB_W | Sub-priority per source, source i at bits i*SUB_W upward |
| cpu_lvl | input | LVL_W | Current processor priority level |
| swt_req | input | 1 | Software trap strobe |
| swt_num | input | VEC_W | Vector of the software trap |
| odd_branch | input | 1 | Branch-to-odd-address fault strobe |
| odd_data | input | 1 | Odd-address word data access fault strobe |
| take | output | 1 | Acknowledge strobe |
| vec | output | VEC_W | Vector index of the acknowledged event |
| new_lvl | output | LVL_W | Processor priority level after the acknowledge |
| irq_clr | output | NUM_SRC | One-cycle clear for the winning request flag |

## Verification
Every result shows up one clock edge after the inputs that cause it. That includes a trap strobe, which is applied at the same edge it arrives. An event that waits out the quiet cycle or loses to a higher class appears at a later edge. The bench drives inputs on the falling edge and computes the expected acknowledge for that cycle from the requirements and its own record of pending traps. It compares the registered outputs on the next falling edge. Its peripheral model drops a flag when it sees the clear pulse, as real hardware would, so the quiet-cycle rule is exercised on every acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Class of the event granted in a cycle, in falling precedence order.
   typedef enum logic [2:0] {
      GK_NONE    = 3'd0,
      GK_HW_BR   = 3'd1,
      GK_HW_DATA = 3'd2,
      GK_SW      = 3'd3,
      GK_IRQ     = 3'd4
   } grant_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned MAX_LVL = 14
) (
   input  logic [NUM_SRC-1:0]       req,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
   input  logic [LVL_W-1:0]         cpu_lvl,
   output logic [NUM_SRC-1:0]       elig
);
   localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAX_LVL);

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      logic [LVL_W-1:0] l;
      assign l        = lvl_flat[gi*LVL_W +: LVL_W];
      assign elig[gi] = req[gi] && (l != '0) && (l <= MAX_L) && (l > cpu_lvl);
   end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned LVL_W    = 4,
   parameter int unsigned SUB_W    = 2,
   parameter bit          SEL_TREE = 1'b1,
   parameter int unsigned IDX_W    = 3
) (
   input  logic [NUM_SRC-1:0]       elig,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
   input  logic [NUM_SRC*SUB_W-1:0] sub_flat,
   output logic                     found,
   output logic [IDX_W-1:0]         win_idx,
   output logic [LVL_W-1:0]         win_lvl
);
   localparam int unsigned KEY_W = LVL_W + SUB_W;
   localparam int unsigned P2    = 1 << IDX_W;

   logic [KEY_W-1:0] win_key;
   assign win_lvl = win_key[KEY_W-1 -: LVL_W];

   if (SEL_TREE) begin : g_tree
      // Pairwise reduction: the left (lower index) entry keeps ties.
      logic             leaf_v [P2];
      logic [KEY_W-1:0] leaf_k [P2];
      logic             t_v    [P2];
      logic [KEY_W-1:0] t_k    [P2];
      logic [IDX_W-1:0] t_i    [P2];

      for (genvar gi = 0; gi < P2; gi++) begin : g_leaf
         if (gi < NUM_SRC) begin : g_real
            assign leaf_v[gi] = elig[gi];
            assign leaf_k[gi] = {lvl_flat[gi*LVL_W +: LVL_W], sub_flat[gi*SUB_W +: SUB_W]};
         end else begin : g_pad
            assign leaf_v[gi] = 1'b0;
            assign leaf_k[gi] = '0;
         end
      end

      always_comb begin
         for (int i = 0; i < P2; i++) begin
            t_v[i] = leaf_v[i];
            t_k[i] = leaf_k[i];
            t_i[i] = IDX_W'(i);
         end
         for (int s = 1; s < P2; s = s * 2) begin
            for (int i = 0; i + s < P2; i = i + 2 * s) begin
               if (t_v[i+s] && (!t_v[i] || (t_k[i+s] > t_k[i]))) begin
                  t_v[i] = 1'b1;
                  t_k[i] = t_k[i+s];
                  t_i[i] = t_i[i+s];
               end
            end
         end
         found   = t_v[0];
         win_key = t_k[0];
         win_idx = t_i[0];
      end
   end else begin : g_linear
      // Ascending scan: only a strictly larger key replaces the holder.
      always_comb begin
         found   = 1'b0;
         win_key = '0;
         win_idx = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found ||
                ({lvl_flat[i*LVL_W +: LVL_W], sub_flat[i*SUB_W +: SUB_W]} > win_key))) begin
               found   = 1'b1;
               win_key = {lvl_flat[i*LVL_W +: LVL_W], sub_flat[i*SUB_W +: SUB_W]};
               win_idx = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/irq_trap_latch.sv
module irq_trap_latch #(
   parameter int unsigned VEC_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             odd_branch,
   input  logic             odd_data,
   input  logic             swt_req,
   input  logic [VEC_W-1:0] swt_num,
   input  logic             took_br,
   input  logic             took_data,
   input  logic             took_sw,
   output logic             br_act,
   output logic             data_act,
   output logic             sw_act,
   output logic [VEC_W-1:0] sw_vec
);
   logic             br_pend, data_pend, sw_pend;
   logic [VEC_W-1:0] sw_num_q;

   // A strobe counts in its own cycle, so traps need no extra latency.
   assign br_act   = br_pend | odd_branch;
   assign data_act = data_pend | odd_data;
   assign sw_act   = sw_pend | swt_req;
   assign sw_vec   = sw_pend ? sw_num_q : swt_num;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_pend   <= 1'b0;
         data_pend <= 1'b0;
         sw_pend   <= 1'b0;
         sw_num_q  <= '0;
      end else begin
         br_pend   <= br_act & ~took_br;
         data_pend <= data_act & ~took_data;
         if (took_sw) begin
            sw_pend <= 1'b0;
         end else if (!sw_pend && swt_req) begin
            sw_pend  <= 1'b1;
            sw_num_q <= swt_num;
         end
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC      = 8,
   parameter int unsigned LVL_W        = 4,
   parameter int unsigned SUB_W        = 2,
   parameter int unsigned VEC_W        = 7,
   parameter int unsigned MAX_LVL      = 14,
   parameter int unsigned HWT_LVL      = 15,
   parameter int unsigned IRQ_VEC_BASE = 32,
   parameter int unsigned HWT_BR_VEC   = 2,
   parameter int unsigned HWT_DATA_VEC = 3,
   parameter bit          SEL_TREE     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       irq_req,
   input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
   input  logic [NUM_SRC*SUB_W-1:0] irq_sub,
   input  logic [LVL_W-1:0]         cpu_lvl,
   input  logic                     swt_req,
   input  logic [VEC_W-1:0]         swt_num,
   input  logic                     odd_branch,
   input  logic                     odd_data,
   output logic                     take,
   output logic [VEC_W-1:0]         vec,
   output logic [LVL_W-1:0]         new_lvl,
   output logic [NUM_SRC-1:0]       irq_clr
);
   localparam int unsigned IDX_W = idx_width(NUM_SRC);

   // Elaboration-time parameter checks.
   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_arbiter: NUM_SRC must be at least 1");
   end
   if (SUB_W < 1 || LVL_W < 2) begin : g_bad_w
      $error("irq_arbiter: SUB_W >= 1 and LVL_W >= 2 required");
   end
   if (MAX_LVL < 1 || MAX_LVL >= (1 << LVL_W) || HWT_LVL >= (1 << LVL_W)) begin : g_bad_lvl
      $error("irq_arbiter: levels do not fit LVL_W");
   end
   if (IRQ_VEC_BASE + NUM_SRC > (1 << VEC_W) ||
       HWT_BR_VEC >= (1 << VEC_W) || HWT_DATA_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_arbiter: vectors do not fit VEC_W");
   end

   logic [NUM_SRC-1:0] elig;
   logic               sel_found;
   logic [IDX_W-1:0]   sel_idx;
   logic [LVL_W-1:0]   sel_lvl;
   logic               br_act, data_act, sw_act;
   logic [VEC_W-1:0]   sw_vec;
   grant_kind_e        gk;
   logic               take_q;
   logic [VEC_W-1:0]   vec_d, vec_q;
   logic [LVL_W-1:0]   lvl_d, lvl_q;
   logic [NUM_SRC-1:0] clr_d, clr_q;

   irq_src_qualify #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .MAX_LVL (MAX_LVL)
   ) u_qual (
      .req      (irq_req),
      .lvl_flat (irq_lvl),
      .cpu_lvl  (cpu_lvl),
      .elig     (elig)
   );

   irq_prio_select #(
      .NUM_SRC  (NUM_SRC),
      .LVL_W    (LVL_W),
      .SUB_W    (SUB_W),
      .SEL_TREE (SEL_TREE),
      .IDX_W    (IDX_W)
   ) u_sel (
      .elig     (elig),
      .lvl_flat (irq_lvl),
      .sub_flat (irq_sub),
      .found    (sel_found),
      .win_idx  (sel_idx),
      .win_lvl  (sel_lvl)
   );

   irq_trap_latch #(
      .VEC_W (VEC_W)
   ) u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .odd_branch (odd_branch),
      .odd_data   (odd_data),
      .swt_req    (swt_req),
      .swt_num    (swt_num),
      .took_br    (gk == GK_HW_BR),
      .took_data  (gk == GK_HW_DATA),
      .took_sw    (gk == GK_SW),
      .br_act     (br_act),
      .data_act   (data_act),
      .sw_act     (sw_act),
      .sw_vec     (sw_vec)
   );

   // Class precedence; the cycle that issues an acknowledge grants nothing.
   always_comb begin
      if (take_q)         gk = GK_NONE;
      else if (br_act)    gk = GK_HW_BR;
      else if (data_act)  gk = GK_HW_DATA;
      else if (sw_act)    gk = GK_SW;
      else if (sel_found) gk = GK_IRQ;
      else                gk = GK_NONE;
   end

   always_comb begin
      vec_d = '0;
      lvl_d = '0;
      clr_d = '0;
      unique case (gk)
         GK_HW_BR: begin
            vec_d = VEC_W'(HWT_BR_VEC);
            lvl_d = LVL_W'(HWT_LVL);
         end
         GK_HW_DATA: begin
            vec_d = VEC_W'(HWT_DATA_VEC);
            lvl_d = LVL_W'(HWT_LVL);
         end
         GK_SW: begin
            vec_d = sw_vec;
            lvl_d = cpu_lvl;
         end
         GK_IRQ: begin
            vec_d          = VEC_W'(IRQ_VEC_BASE) + VEC_W'(sel_idx);
            lvl_d          = sel_lvl;
            clr_d[sel_idx] = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         lvl_q  <= '0;
         clr_q  <= '0;
      end else begin
         take_q <= (gk != GK_NONE);
         vec_q  <= vec_d;
         lvl_q  <= lvl_d;
         clr_q  <= clr_d;
      end
   end

   assign take    = take_q;
   assign vec     = vec_q;
   assign new_lvl = lvl_q;
   assign irq_clr = clr_q;

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
   parameter int unsigned NUM_SRC      = 8,
   parameter int unsigned LVL_W        = 4,
   parameter int unsigned VEC_W        = 7,
   parameter int unsigned MAX_LVL      = 14,
   parameter int unsigned HWT_LVL      = 15,
   parameter int unsigned IRQ_VEC_BASE = 32,
   parameter int unsigned HWT_BR_VEC   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LVL_W-1:0]   cpu_lvl,
   input logic               odd_branch,
   input logic               take,
   input logic [VEC_W-1:0]   vec,
   input logic [LVL_W-1:0]   new_lvl,
   input logic [NUM_SRC-1:0] irq_clr
);
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (vec == '0 && new_lvl == '0 && irq_clr == '0));

   a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   a_r9_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_clr) && ((irq_clr != '0) -> take));

   a_r2_level_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr != '0) |-> (new_lvl > $past(cpu_lvl) && new_lvl != '0 &&
                            new_lvl <= LVL_W'(MAX_LVL)));

   a_r7_branch_first: assert property (@(posedge clk) disable iff (!rst_n)
      (odd_branch && !take) |=> (take && vec == VEC_W'(HWT_BR_VEC) &&
                                 new_lvl == LVL_W'(HWT_LVL)));

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_vec
      a_r5_clr_vec: assert property (@(posedge clk) disable iff (!rst_n)
         irq_clr[gi] |-> (vec == VEC_W'(IRQ_VEC_BASE + gi)));
   end

endmodule

bind irq_arbiter irq_arbiter_chk #(
   .NUM_SRC      (NUM_SRC),
   .LVL_W        (LVL_W),
   .VEC_W        (VEC_W),
   .MAX_LVL      (MAX_LVL),
   .HWT_LVL      (HWT_LVL),
   .IRQ_VEC_BASE (IRQ_VEC_BASE),
   .HWT_BR_VEC   (HWT_BR_VEC)
) u_chk (.*);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
   localparam int N     = 8;
   localparam int LW    = 4;
   localparam int SW    = 2;
   localparam int VW    = 7;
   localparam int MAXL  = 14;
   localparam int HWL   = 15;
   localparam int VBASE = 32;
   localparam int VBR   = 2;
   localparam int VDT   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    irq_req = '0;
   logic [N*LW-1:0] irq_lvl = '0;
   logic [N*SW-1:0] irq_sub = '0;
   logic [LW-1:0]   cpu_lvl = '0;
   logic            swt_req = 1'b0;
   logic [VW-1:0]   swt_num = '0;
   logic            odd_branch = 1'b0;
   logic            odd_data = 1'b0;
   logic            take;
   logic [VW-1:0]   vec;
   logic [LW-1:0]   new_lvl;
   logic [N-1:0]    irq_clr;

   always #4 clk = ~clk;

   irq_arbiter u_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .irq_sub(irq_sub), .cpu_lvl(cpu_lvl), .swt_req(swt_req), .swt_num(swt_num),
      .odd_branch(odd_branch), .odd_data(odd_data), .take(take), .vec(vec),
      .new_lvl(new_lvl), .irq_clr(irq_clr)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Stimulus state and the bench's own record of pending traps.
   logic [N-1:0]  pend_q = '0;
   int            lv [N];
   int            sb [N];
   bit            m_take = 0, m_br = 0, m_dt = 0, m_sw = 0;
   int            m_swn = 0;
   bit            e_take;
   int            e_vec, e_lvl;
   logic [N-1:0]  e_clr;
   string         e_tag;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected acknowledge for the inputs now driven, then pending-state update.
   task automatic predict();
      int kind = 0;
      int best = -1;
      e_take = 0; e_vec = 0; e_lvl = 0; e_clr = '0;
      if (m_take) begin
         kind = 0;
         e_tag = "R8";
      end else if (m_br || odd_branch) kind = 1;
      else if (m_dt || odd_data) kind = 2;
      else if (m_sw || swt_req) kind = 3;
      else begin
         for (int i = 0; i < N; i++) begin
            if (pend_q[i] && lv[i] != 0 && lv[i] <= MAXL && lv[i] > int'(cpu_lvl)) begin
               if (best < 0 || lv[i] > lv[best] || (lv[i] == lv[best] && sb[i] > sb[best]))
                  best = i;
            end
         end
         kind = (best >= 0) ? 4 : 0;
         if (best < 0) e_tag = "R2";
      end
      case (kind)
         1: begin e_vec = VBR; e_lvl = HWL; e_tag = "R7"; end
         2: begin e_vec = VDT; e_lvl = HWL; e_tag = "R7"; end
         3: begin e_vec = m_sw ? m_swn : int'(swt_num); e_lvl = int'(cpu_lvl); e_tag = "R6"; end
         4: begin e_vec = VBASE + best; e_lvl = lv[best]; e_clr[best] = 1'b1; e_tag = "R5"; end
         default: ;
      endcase
      e_take = (kind != 0);
      m_br = (m_br || odd_branch) && kind != 1;
      m_dt = (m_dt || odd_data) && kind != 2;
      if (kind == 3) m_sw = 0;
      else if (!m_sw && swt_req) begin m_sw = 1; m_swn = int'(swt_num); end
      m_take = e_take;
   endtask

   // One cycle: drive at the falling edge, compare after the next rising edge.
   task automatic cyc(string tag);
      for (int i = 0; i < N; i++) begin
         irq_lvl[i*LW +: LW] = LW'(lv[i]);
         irq_sub[i*SW +: SW] = SW'(sb[i]);
      end
      irq_req = pend_q;
      predict();
      if (tag != "") e_tag = tag;
      @(posedge clk);
      @(negedge clk);
      chk(e_tag, "take", int'(take), int'(e_take));
      chk(e_tag, "vec", int'(vec), e_vec);
      chk(e_tag, "new_lvl", int'(new_lvl), e_lvl);
      chk(e_tag, "irq_clr", int'(irq_clr), int'(e_clr));
      chk("R9", "clr bits", $countones(irq_clr), (take && irq_clr != '0) ? 1 : 0);
      pend_q = pend_q & ~irq_clr;   // peripheral drops its flag on the clear
      swt_req = 0; odd_branch = 0; odd_data = 0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc("");
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin lv[i] = 0; sb[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R1", "take in reset", int'(take), 0);
      chk("R1", "vec in reset", int'(vec), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "take after reset", int'(take), 0);
      chk("R1", "clr after reset", int'(irq_clr), 0);

      // R2: equal to cpu level, level 0 and level above MAX_LVL never win.
      cpu_lvl = 5;
      lv[0] = 5; lv[1] = 0; lv[2] = 15;
      pend_q = 8'b0000_0111;
      cyc("R2"); cyc("R2");
      cpu_lvl = 4;
      cyc("R2"); idle(2);
      chk("R2", "flags left", int'(pend_q), 32'h6);
      pend_q = '0;

      // R3: highest level first, then the other one.
      cpu_lvl = 0; lv[1] = 3; lv[6] = 9;
      pend_q = 8'b0100_0010;
      cyc("R3"); cyc("R8"); cyc("R3"); idle(1);

      // R4: sub-priority, then lowest index.
      lv[2] = 7; lv[5] = 7; sb[2] = 1; sb[5] = 3;
      pend_q = 8'b0010_0100;
      cyc("R4"); idle(1); cyc("R4"); idle(1);
      sb[5] = 1; lv[3] = 7; sb[3] = 1;
      pend_q = 8'b0010_1100;
      cyc("R4"); idle(1); cyc("R4"); idle(1); cyc("R4"); idle(1);

      // R6: software trap beats a peripheral and inherits cpu level.
      cpu_lvl = 6; lv[4] = 12; pend_q = 8'b0001_0000;
      swt_req = 1; swt_num = 7'd77;
      cyc("R6"); cyc("R8"); cyc("R5"); idle(1);

      // R7: both faults plus a software trap at the top cpu level.
      cpu_lvl = 15; lv[3] = 14; pend_q = 8'b0000_1000;
      odd_branch = 1; odd_data = 1; swt_req = 1; swt_num = 7'd9;
      cyc("R7"); swt_req = 1; swt_num = 7'd10;
      cyc("R8"); cyc("R7"); cyc("R8"); cyc("R6"); idle(2);
      pend_q = '0; cpu_lvl = 0;

      // R8: a strobe during the issuing cycle is served right after.
      lv[0] = 2; pend_q = 8'b0000_0001;
      cyc("R5"); odd_data = 1; cyc("R8"); cyc("R8"); idle(2);

      // Constrained random traffic.
      void'($urandom(32'd1234));
      for (int t = 0; t < 4000; t++) begin
         if (t % 64 == 0)
            for (int i = 0; i < N; i++) begin lv[i] = $urandom_range(0, 15); sb[i] = $urandom_range(0, 3); end
         if ($urandom_range(0, 9) == 0) cpu_lvl = LW'($urandom_range(0, 15));
         else if ($urandom_range(0, 5) == 0) cpu_lvl = 0;
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 11) == 0) pend_q[i] = 1'b1;
         swt_req    = ($urandom_range(0, 29) == 0);
         swt_num    = VW'($urandom_range(0, 127));
         odd_branch = ($urandom_range(0, 59) == 0);
         odd_data   = ($urandom_range(0, 49) == 0);
         cyc("");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R8: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule